// File: doc/BRIEF.md
# Bus Error Latch and Double-Fault Detector

This block sits between a processor's bus interface and its exception sequencer. It samples the bus-error input once per bus cycle, on the clock where the cycle ends. Then it holds the error as a pending condition until the instruction in flight reaches its boundary, and only then asks the sequencer for bus-error exception processing. The request stays up until the sequencer acknowledges it. The latch stays set through exception processing and clears when the first instruction of the handler executes.

Three situations turn an error into a double bus fault, which halts the processor until reset. The first is an error after bus-error processing has begun but before the handler's first instruction. The second is any error between reset and the first completed instruction. The third is an error while the sequencer is loading exception information for a bus error it has already requested. The block also guards the data path. A bus cycle that ends in error does not update the captured read data. An instruction prefetch that ends in error loads the all-ones precharge pattern into the instruction register. For the exception frame, the block records whether the faulting access was a prefetch and whether it was in program space.

Top module: `berr_guard`

## Requirements
- R1: After synchronous reset the exception request and the halt output are low, both recorded attributes are 0, the instruction register holds all ones and the read-data register holds 0.
- R2: An error event is cyc_end_i, berr_i and not halt_in_i in the same cycle. An error with halt_in_i high, or berr_i without cyc_end_i, latches nothing, so no request follows at the next instruction boundary.
- R3: A latched error raises berr_req_o one cycle after the first insn_done_i pulse that comes strictly after the latching edge. An insn_done_i pulse in the same cycle as the error event does not count. The request stays high until exc_start_i is sampled, and drops in the cycle after.
- R4: Several error events before the request is acknowledged produce exactly one request. After exc_start_i no second request appears. An error while the request is pending and exc_loading_i is low does not halt.
- R5: handler_first_i, sampled after exc_start_i, clears the latch. A later error event then produces a normal request and no halt.
- R6: An error event after exc_start_i and before handler_first_i sets dbl_halt_o in the next cycle.
- R7: An error event after reset and before the first insn_done_i pulse sets dbl_halt_o in the next cycle.
- R8: An error event while exc_loading_i is high and a bus-error request is raised sets dbl_halt_o in the next cycle.
- R9: dbl_halt_o stays high until reset. While it is high, berr_req_o stays low, even after new errors and instruction boundaries.
- R10: On the error event that sets the latch, fault_prog_o takes prog_space_i (1 = program space) and fault_pref_o takes prefetch_i. Later error events before the latch clears do not change them.
- R11: A prefetch cycle (cyc_end_i and prefetch_i) without error loads bus_data_i into ir_o. One ending with berr_i loads all ones (0xFFFF at DATA_W = 16).
- R12: A non-prefetch cycle without error loads bus_data_i into rd_data_o. A cycle ending with berr_i leaves rd_data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end_i | input | 1 | Current bus cycle terminates this clock |
| berr_i | input | 1 | Bus error signalled for the terminating cycle |
| halt_in_i | input | 1 | Halt input; errors are not exceptions while high |
| prefetch_i | input | 1 | Terminating cycle is an instruction prefetch |
| prog_space_i | input | 1 | Terminating cycle is a program-space access (0 = data space) |
| bus_data_i | input | DATA_W | Data on the bus at cycle end |
| insn_done_i | input | 1 | Current instruction completes this clock |
| exc_start_i | input | 1 | Sequencer begins bus-error exception processing |
| exc_loading_i | input | 1 | Sequencer is loading exception information |
| handler_first_i | input | 1 | First instruction of the bus-error handler executes |
| berr_req_o | output | 1 | Bus-error exception request |
| dbl_halt_o | output | 1 | Double bus fault halt |
| fault_prog_o | output | 1 | Faulting access was program space |
| fault_pref_o | output | 1 | Faulting access was a prefetch |
| ir_o | output | DATA_W | Instruction register contents |
| rd_data_o | output | DATA_W | Captured read data |

## Verification
The bench builds the block with the default DATA_W of 16. At that width the precharge pattern is the literal 0xFFFF, and bus data patterns such as 0x1234 and 0xA5C3 are easy to tell apart from it. Starting each scenario from reset reaches every latch phase, so each of the three double-fault causes can be provoked on its own. Nearby cases that must not halt are checked as well: an error while the request is pending with no loading, and an error after the latch has cleared.

// File: rtl/berr_pkg.sv
package berr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PEND = 2'd1,
        PH_REQ  = 2'd2,
        PH_EXC  = 2'd3
    } berr_phase_e;

    typedef struct packed {
        logic prog;
        logic pref;
    } access_attr_t;

    typedef struct packed {
        logic cyc_end;
        logic berr;
        logic halt_in;
        logic prefetch;
        logic prog_space;
    } bus_term_t;

    function automatic logic is_err_event(input bus_term_t t);
        return t.cyc_end & t.berr & ~t.halt_in;
    endfunction

    function automatic logic in_processing(input berr_phase_e p);
        return (p == PH_REQ) || (p == PH_EXC);
    endfunction

endpackage

// File: rtl/berr_latch_fsm.sv
module berr_latch_fsm
    import berr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bus_term_t    term,
    input  logic         insn_done,
    input  logic         exc_start,
    input  logic         handler_first,
    output berr_phase_e  phase,
    output access_attr_t attr,
    output logic         err_ev
);

    berr_phase_e phase_q, phase_d;
    access_attr_t attr_q;

    assign err_ev = is_err_event(term);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (err_ev)        phase_d = PH_PEND;
            PH_PEND: if (insn_done)     phase_d = PH_REQ;
            PH_REQ:  if (exc_start)     phase_d = PH_EXC;
            PH_EXC:  if (handler_first) phase_d = PH_IDLE;
            default:                    phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            attr_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_IDLE && err_ev) begin
                attr_q.prog <= term.prog_space;
                attr_q.pref <= term.prefetch;
            end
        end
    end

    assign phase = phase_q;
    assign attr  = attr_q;

    // R2: an error masked by the halt input leaves the idle latch idle
    assert_halt_masks_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && term.cyc_end && term.berr && term.halt_in) |=> (phase_q == PH_IDLE));

    // R5: the handler's first instruction releases the latch
    assert_latch_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXC && handler_first) |=> (phase_q == PH_IDLE));

    // R10: recorded attributes do not move while the latch is held
    assert_attr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> $stable(attr_q));

endmodule

// File: rtl/berr_dblfault.sv
module berr_dblfault
    import berr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        err_ev,
    input  berr_phase_e phase,
    input  logic        exc_loading,
    input  logic        insn_done,
    output logic        halted
);

    logic post_reset_q;
    logic halted_q;
    logic cause_reset, cause_exc, cause_load;

    assign cause_reset = err_ev & post_reset_q;
    assign cause_exc   = err_ev & (phase == PH_EXC);
    assign cause_load  = err_ev & exc_loading & in_processing(phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            post_reset_q <= 1'b1;
            halted_q     <= 1'b0;
        end else begin
            if (insn_done) post_reset_q <= 1'b0;
            if (cause_reset || cause_exc || cause_load) halted_q <= 1'b1;
        end
    end

    assign halted = halted_q;

    // R9: once halted, only reset releases the halt
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> halted_q);

    // R7: an error before the first completed instruction halts
    assert_reset_window_R7: assert property (@(posedge clk) disable iff (rst)
        (post_reset_q && err_ev) |=> halted_q);

    // R6: an error during bus-error processing halts
    assert_exc_window_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXC && err_ev) |=> halted_q);

endmodule

// File: rtl/berr_capture.sv
module berr_capture
    import berr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_term_t         term,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] PRECHARGE = {DATA_W{1'b1}};

    logic [DATA_W-1:0] ir_q, rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= PRECHARGE;
            rd_q <= '0;
        end else if (term.cyc_end) begin
            if (term.prefetch) begin
                ir_q <= term.berr ? PRECHARGE : bus_data;
            end else if (!term.berr) begin
                rd_q <= bus_data;
            end
        end
    end

    assign ir      = ir_q;
    assign rd_data = rd_q;

    // R11: an errored prefetch leaves the precharge pattern in the instruction register
    assert_ir_precharge_R11: assert property (@(posedge clk) disable iff (rst)
        (term.cyc_end && term.prefetch && term.berr) |=> (ir_q == PRECHARGE));

    // R12: an errored cycle never updates read data
    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (term.cyc_end && term.berr) |=> $stable(rd_q));

endmodule

// File: rtl/berr_guard.sv
module berr_guard
    import berr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_end_i,
    input  logic              berr_i,
    input  logic              halt_in_i,
    input  logic              prefetch_i,
    input  logic              prog_space_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              insn_done_i,
    input  logic              exc_start_i,
    input  logic              exc_loading_i,
    input  logic              handler_first_i,
    output logic              berr_req_o,
    output logic              dbl_halt_o,
    output logic              fault_prog_o,
    output logic              fault_pref_o,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] rd_data_o
);

    bus_term_t    term;
    berr_phase_e  phase;
    access_attr_t attr;
    logic         err_ev;
    logic         halted;

    assign term = '{cyc_end:    cyc_end_i,
                    berr:       berr_i,
                    halt_in:    halt_in_i,
                    prefetch:   prefetch_i,
                    prog_space: prog_space_i};

    berr_latch_fsm u_latch (
        .clk          (clk),
        .rst          (rst),
        .term         (term),
        .insn_done    (insn_done_i),
        .exc_start    (exc_start_i),
        .handler_first(handler_first_i),
        .phase        (phase),
        .attr         (attr),
        .err_ev       (err_ev)
    );

    berr_dblfault u_dbl (
        .clk        (clk),
        .rst        (rst),
        .err_ev     (err_ev),
        .phase      (phase),
        .exc_loading(exc_loading_i),
        .insn_done  (insn_done_i),
        .halted     (halted)
    );

    berr_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .term    (term),
        .bus_data(bus_data_i),
        .ir      (ir_o),
        .rd_data (rd_data_o)
    );

    assign berr_req_o   = (phase == PH_REQ) && !halted;
    assign dbl_halt_o   = halted;
    assign fault_prog_o = attr.prog;
    assign fault_pref_o = attr.pref;

    // R9: no request is presented while halted
    assert_req_gated_R9: assert property (@(posedge clk) disable iff (rst)
        dbl_halt_o |-> !berr_req_o);

    // R3: a request only rises right after an instruction boundary
    assert_req_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(berr_req_o) |-> $past(insn_done_i));

    // R3: an unacknowledged request holds
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (berr_req_o && !exc_start_i && !halted && !err_ev) |=> berr_req_o);

endmodule

// File: tb/tb_berr_guard.sv
module tb_berr_guard;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst;
    logic cyc_end_i, berr_i, halt_in_i, prefetch_i, prog_space_i;
    logic [DW-1:0] bus_data_i;
    logic insn_done_i, exc_start_i, exc_loading_i, handler_first_i;
    logic berr_req_o, dbl_halt_o, fault_prog_o, fault_pref_o;
    logic [DW-1:0] ir_o, rd_data_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    berr_guard #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .cyc_end_i(cyc_end_i), .berr_i(berr_i), .halt_in_i(halt_in_i),
        .prefetch_i(prefetch_i), .prog_space_i(prog_space_i),
        .bus_data_i(bus_data_i), .insn_done_i(insn_done_i),
        .exc_start_i(exc_start_i), .exc_loading_i(exc_loading_i),
        .handler_first_i(handler_first_i),
        .berr_req_o(berr_req_o), .dbl_halt_o(dbl_halt_o),
        .fault_prog_o(fault_prog_o), .fault_pref_o(fault_pref_o),
        .ir_o(ir_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cyc_end_i = 0; berr_i = 0; halt_in_i = 0; prefetch_i = 0; prog_space_i = 0;
        bus_data_i = '0; insn_done_i = 0; exc_start_i = 0; exc_loading_i = 0;
        handler_first_i = 0;
    endtask

    // inputs are set at a negedge; one posedge passes; back at the next negedge
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic done_pulse();
        insn_done_i = 1; tick();
    endtask

    task automatic bus_err(input logic pref, input logic prog);
        cyc_end_i = 1; berr_i = 1; prefetch_i = pref; prog_space_i = prog; tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req", berr_req_o, 0);
        chk("R1 halt", dbl_halt_o, 0);
        chk("R1 prog", fault_prog_o, 0);
        chk("R1 pref", fault_pref_o, 0);
        chk("R1 ir", ir_o, 16'hFFFF);
        chk("R1 rd", rd_data_o, 0);
    endtask

    task automatic t_ignored();
        do_reset(); done_pulse();
        cyc_end_i = 1; berr_i = 1; halt_in_i = 1; tick();
        berr_i = 1; tick();
        done_pulse();
        tick();
        chk("R2 no request", berr_req_o, 0);
        chk("R2 no halt", dbl_halt_o, 0);
    endtask

    task automatic t_defer();
        do_reset(); done_pulse();
        cyc_end_i = 1; berr_i = 1; prog_space_i = 1; insn_done_i = 1; tick();
        chk("R3 not at same boundary", berr_req_o, 0);
        chk("R10 prog", fault_prog_o, 1);
        chk("R10 pref", fault_pref_o, 0);
        tick();
        chk("R3 waits", berr_req_o, 0);
        done_pulse();
        chk("R3 raised", berr_req_o, 1);
        tick();
        chk("R3 held", berr_req_o, 1);
        exc_start_i = 1; tick();
        chk("R3 dropped", berr_req_o, 0);
    endtask

    task automatic t_merge();
        do_reset(); done_pulse();
        bus_err(1, 1);
        bus_err(0, 0);
        chk("R10 first kept prog", fault_prog_o, 1);
        chk("R10 first kept pref", fault_pref_o, 1);
        done_pulse();
        chk("R4 one request", berr_req_o, 1);
        bus_err(0, 0);
        chk("R4 no halt while pending", dbl_halt_o, 0);
        exc_start_i = 1; tick();
        done_pulse(); done_pulse();
        chk("R4 no second request", berr_req_o, 0);
        handler_first_i = 1; tick();
        bus_err(0, 1);
        done_pulse();
        chk("R5 fresh request", berr_req_o, 1);
        chk("R5 no halt", dbl_halt_o, 0);
    endtask

    task automatic t_dbl_exc();
        do_reset(); done_pulse();
        bus_err(0, 0); done_pulse();
        exc_start_i = 1; tick();
        chk("R6 before", dbl_halt_o, 0);
        bus_err(0, 0);
        chk("R6 halt", dbl_halt_o, 1);
        chk("R9 req low", berr_req_o, 0);
        handler_first_i = 1; tick();
        bus_err(0, 0); done_pulse(); exc_start_i = 1; tick();
        chk("R9 sticky", dbl_halt_o, 1);
        chk("R9 no request", berr_req_o, 0);
        do_reset();
        chk("R9 reset clears", dbl_halt_o, 0);
    endtask

    task automatic t_dbl_reset();
        do_reset();
        bus_err(1, 1);
        chk("R7 halt", dbl_halt_o, 1);
        done_pulse();
        chk("R9 no request after reset fault", berr_req_o, 0);
    endtask

    task automatic t_dbl_load();
        do_reset(); done_pulse();
        bus_err(0, 0); done_pulse();
        chk("R8 requested", berr_req_o, 1);
        cyc_end_i = 1; berr_i = 1; exc_loading_i = 1; tick();
        chk("R8 halt", dbl_halt_o, 1);
        chk("R9 request masked", berr_req_o, 0);
    endtask

    task automatic t_data();
        do_reset(); done_pulse();
        cyc_end_i = 1; prefetch_i = 1; bus_data_i = 16'h1234; tick();
        chk("R11 ir loaded", ir_o, 16'h1234);
        cyc_end_i = 1; prefetch_i = 1; berr_i = 1; bus_data_i = 16'h5555; tick();
        chk("R11 ir precharge", ir_o, 16'hFFFF);
        cyc_end_i = 1; bus_data_i = 16'hA5C3; tick();
        chk("R12 rd loaded", rd_data_o, 16'hA5C3);
        chk("R12 ir untouched", ir_o, 16'hFFFF);
        cyc_end_i = 1; berr_i = 1; bus_data_i = 16'h0F0F; tick();
        chk("R12 rd held", rd_data_o, 16'hA5C3);
        bus_data_i = 16'h7777; tick();
        chk("R12 no capture without cycle end", rd_data_o, 16'hA5C3);
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_ignored();
        t_defer();
        t_merge();
        t_dbl_exc();
        t_dbl_reset();
        t_dbl_load();
        t_data();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule